// File: doc/BRIEF.md
# Backplane Shared-Memory Window Control Register

This block is a one-byte control/status register on the local processor bus. It governs how a dual-port memory and its mailbox interrupt are made visible to a 24-bit backplane. The register holds a 4-bit window base and a window enable. It also holds a bus-monitor enable and a sticky mailbox-pending flag, and it reports a read-only strap that tells whether the board sits in the first slot.

From these fields the block decodes backplane addresses against a 1 MB window. The top four address bits select one of sixteen window positions. The block also times every backplane cycle. A cycle that stays open for too long ends in a one-cycle bus-error pulse. The timeout is a fixed number of clock cycles, derived from the clock frequency and a 128 us limit. At 16 MHz this is 2048 cycles.

The processor reads and writes the register at byte offset 5 of its select region. The mailbox-pending flag drives an interrupt output until software clears it.

Top module: `shared_win_csr`

## Requirements
- R1: After reset the register reads 0x00 apart from the first-slot bit; mbox_irq_o, berr_o and win_hit_o are 0.
- R2: With cpu_sel_i high and cpu_addr_i equal to 5, cpu_rdata_o shows bit 7 mailbox pending, bit 6 window enable, bit 5 monitor enable, bit 4 first-slot strap, and bits 3..0 the window base. Any other offset, or no select, reads 0x00.
- R3: A write (cpu_sel_i and cpu_we_i high, offset 5) loads bits 6, 5 and 3..0 from cpu_wdata_i at the clock edge. Writes at other offsets or without select change nothing.
- R4: Bit 4 ignores writes and always reads the current value of slot1_strap_i (1 in slot 1, else 0).
- R5: A one-cycle mbox_wr_i pulse sets the pending flag at the next edge, and mbox_irq_o equals the pending flag.
- R6: Writing 1 to bit 7 clears the pending flag, while writing 0 leaves it unchanged. A mailbox pulse in the same cycle as a clearing write wins, and the flag stays set.
- R7: win_hit_o is high in the same cycle only when the window enable is 1, bp_strobe_i is 1 and bp_addr_i[23:20] equals the base field.
- R8: With the monitor enabled, a cycle is counted from the first edge that sees bp_strobe_i high. If bp_strobe_i stays high without bp_ack_i, berr_o pulses high for exactly one clock, TERM cycles after that edge, where TERM = CLK_HZ*TIMEOUT_US/1e6.
- R9: bp_ack_i during a cycle stops its timer, so no bus error follows. Each cycle gives at most one bus error, and a new rise of bp_strobe_i restarts the count from zero.
- R10: With the monitor enable cleared, the timer does not advance and berr_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot1_strap_i | input | 1 | High when the board occupies the first slot |
| cpu_sel_i | input | 1 | Local bus select for the register region |
| cpu_we_i | input | 1 | Local bus write enable |
| cpu_addr_i | input | ADDR_W | Byte offset within the region |
| cpu_wdata_i | input | 8 | Write data |
| cpu_rdata_o | output | 8 | Read data (0 when not addressed) |
| mbox_wr_i | input | 1 | One-cycle pulse when the backplane writes the mailbox |
| bp_strobe_i | input | 1 | Backplane cycle active |
| bp_ack_i | input | 1 | Backplane cycle acknowledged |
| bp_addr_i | input | BP_ADDR_W | Backplane address |
| win_hit_o | output | 1 | Access falls in the enabled window |
| mbox_irq_o | output | 1 | Mailbox interrupt, active high |
| berr_o | output | 1 | One-cycle bus-error pulse on timeout |

## Verification
The decoder is swept across all sixteen values of the top address nibble, both with the window enabled and with it disabled. The sweep shows that exactly one position hits, and that the enable and the strobe each gate the hit. The timer is tried with four cycle patterns. A cycle held open past the limit shows the pulse and its position. A cycle acknowledged halfway shows that the acknowledge stops the timer. Two near-limit cycles separated by one idle clock show that a new strobe restarts the count. A long cycle with the monitor disabled shows that the enable gates the error. The register is tried with all-ones and all-zeros writes, writes at a wrong offset, and mailbox pulses that collide with clearing writes. These separate the writable fields, the strap bit and the set-wins priority.

// File: rtl/shared_win_pkg.sv
package shared_win_pkg;
  localparam int BASE_W = 4;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              pend;
    logic              win_en;
    logic              mon_en;
    logic              slot1;
    logic [BASE_W-1:0] base;
  } csr_t;
endpackage

// File: rtl/swin_csr_reg.sv
module swin_csr_reg
  import shared_win_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int REG_OFS = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              mbox_set_i,
  input  logic              slot1_i,
  output logic [DATA_W-1:0] rdata_o,
  output csr_t              csr_o
);
  logic              addr_hit, wr_en;
  logic              pend_q, win_en_q, mon_en_q;
  logic [BASE_W-1:0] base_q;
  csr_t              wd;
  logic              unused_wd_slot;

  assign wd             = csr_t'(wdata_i);
  assign unused_wd_slot = wd.slot1;
  assign addr_hit       = sel_i && (addr_i == ADDR_W'(REG_OFS));
  assign wr_en          = addr_hit && we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_en_q <= 1'b0;
      mon_en_q <= 1'b0;
      base_q   <= '0;
    end else if (wr_en) begin
      win_en_q <= wd.win_en;
      mon_en_q <= wd.mon_en;
      base_q   <= wd.base;
    end
  end

  // set has priority over write-one-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pend_q <= 1'b0;
    else if (mbox_set_i)        pend_q <= 1'b1;
    else if (wr_en && wd.pend)  pend_q <= 1'b0;
  end

  assign csr_o   = '{pend: pend_q, win_en: win_en_q, mon_en: mon_en_q,
                     slot1: slot1_i, base: base_q};
  assign rdata_o = addr_hit ? DATA_W'(csr_o) : '0;
endmodule

// File: rtl/swin_decode.sv
module swin_decode #(
  parameter int BP_ADDR_W = 24,
  parameter int BASE_W    = 4
) (
  input  logic                 win_en_i,
  input  logic                 strobe_i,
  input  logic [BP_ADDR_W-1:0] addr_i,
  input  logic [BASE_W-1:0]    base_i,
  output logic                 hit_o
);
  localparam int LSB = BP_ADDR_W - BASE_W;

  logic [BASE_W-1:0] bit_eq;
  logic              unused_low;

  for (genvar b = 0; b < BASE_W; b++) begin : g_cmp
    assign bit_eq[b] = (addr_i[LSB+b] == base_i[b]);
  end

  assign unused_low = ^addr_i[LSB-1:0];
  assign hit_o      = win_en_i && strobe_i && (&bit_eq);
endmodule

// File: rtl/swin_bus_mon.sv
module swin_bus_mon #(
  parameter int TERM = 2048
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic strobe_i,
  input  logic ack_i,
  output logic berr_o
);
  localparam int CNT_W = (TERM > 2) ? $clog2(TERM) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TERM - 1);

  logic             strobe_q, stopped_q, berr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             start;

  assign start = strobe_i && !strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q  <= 1'b0;
      stopped_q <= 1'b0;
      berr_q    <= 1'b0;
      cnt_q     <= '0;
    end else begin
      strobe_q <= strobe_i;
      berr_q   <= 1'b0;
      if (start) begin
        cnt_q     <= '0;
        stopped_q <= 1'b0;
      end else if (strobe_i && ack_i) begin
        stopped_q <= 1'b1;
      end else if (strobe_i && !stopped_q && en_i) begin
        if (cnt_q == LAST) begin
          berr_q    <= 1'b1;
          stopped_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign berr_o = berr_q;
endmodule

// File: rtl/shared_win_csr.sv
module shared_win_csr
  import shared_win_pkg::*;
#(
  parameter int CLK_HZ     = 16_000_000,
  parameter int TIMEOUT_US = 128,
  parameter int ADDR_W     = 3,
  parameter int REG_OFS    = 5,
  parameter int BP_ADDR_W  = 24
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 slot1_strap_i,
  input  logic                 cpu_sel_i,
  input  logic                 cpu_we_i,
  input  logic [ADDR_W-1:0]    cpu_addr_i,
  input  logic [DATA_W-1:0]    cpu_wdata_i,
  output logic [DATA_W-1:0]    cpu_rdata_o,
  input  logic                 mbox_wr_i,
  input  logic                 bp_strobe_i,
  input  logic                 bp_ack_i,
  input  logic [BP_ADDR_W-1:0] bp_addr_i,
  output logic                 win_hit_o,
  output logic                 mbox_irq_o,
  output logic                 berr_o
);
  localparam longint TERM_L = (longint'(CLK_HZ) * TIMEOUT_US) / 1_000_000;
  localparam int     TERM   = int'(TERM_L);

  csr_t csr_q;

  swin_csr_reg #(.ADDR_W(ADDR_W), .REG_OFS(REG_OFS)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (cpu_sel_i),
    .we_i      (cpu_we_i),
    .addr_i    (cpu_addr_i),
    .wdata_i   (cpu_wdata_i),
    .mbox_set_i(mbox_wr_i),
    .slot1_i   (slot1_strap_i),
    .rdata_o   (cpu_rdata_o),
    .csr_o     (csr_q)
  );

  swin_decode #(.BP_ADDR_W(BP_ADDR_W), .BASE_W(BASE_W)) u_dec (
    .win_en_i(csr_q.win_en),
    .strobe_i(bp_strobe_i),
    .addr_i  (bp_addr_i),
    .base_i  (csr_q.base),
    .hit_o   (win_hit_o)
  );

  swin_bus_mon #(.TERM(TERM)) u_mon (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (csr_q.mon_en),
    .strobe_i(bp_strobe_i),
    .ack_i   (bp_ack_i),
    .berr_o  (berr_o)
  );

  assign mbox_irq_o = csr_q.pend;
endmodule

// File: rtl/shared_win_csr_chk.sv
module shared_win_csr_chk #(
  parameter int ADDR_W    = 3,
  parameter int REG_OFS   = 5,
  parameter int BP_ADDR_W = 24
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 slot1_strap_i,
  input logic                 cpu_sel_i,
  input logic                 cpu_we_i,
  input logic [ADDR_W-1:0]    cpu_addr_i,
  input logic [7:0]           cpu_wdata_i,
  input logic [7:0]           cpu_rdata_o,
  input logic                 mbox_wr_i,
  input logic                 bp_strobe_i,
  input logic                 bp_ack_i,
  input logic [BP_ADDR_W-1:0] bp_addr_i,
  input logic                 win_hit_o,
  input logic                 mbox_irq_o,
  input logic                 berr_o,
  input logic [7:0]           csr_q
);
  logic addressed, clr_wr;
  assign addressed = cpu_sel_i && (cpu_addr_i == ADDR_W'(REG_OFS));
  assign clr_wr    = addressed && cpu_we_i && cpu_wdata_i[7];

  AST_IDLE_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addressed |-> cpu_rdata_o == 8'h00);                                   // R2
  AST_SLOT_BIT_STRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addressed |-> cpu_rdata_o[4] == slot1_strap_i);                         // R4
  AST_MBOX_SETS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mbox_wr_i |=> mbox_irq_o);                                              // R5
  AST_IRQ_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr && !mbox_wr_i) |=> !mbox_irq_o);                                // R6
  AST_NO_HIT_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_q[6] |-> !win_hit_o);                                              // R7
  AST_HIT_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_hit_o |-> bp_strobe_i && bp_addr_i[BP_ADDR_W-1 -: 4] == csr_q[3:0]); // R7
  AST_BERR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    berr_o |=> !berr_o);                                                    // R8
  AST_BERR_OPEN_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    berr_o |-> $past(bp_strobe_i && !bp_ack_i));                            // R9
  AST_BERR_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    berr_o |-> $past(csr_q[5]));                                            // R10
endmodule

bind shared_win_csr shared_win_csr_chk #(
  .ADDR_W(ADDR_W), .REG_OFS(REG_OFS), .BP_ADDR_W(BP_ADDR_W)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .slot1_strap_i(slot1_strap_i),
  .cpu_sel_i    (cpu_sel_i),
  .cpu_we_i     (cpu_we_i),
  .cpu_addr_i   (cpu_addr_i),
  .cpu_wdata_i  (cpu_wdata_i),
  .cpu_rdata_o  (cpu_rdata_o),
  .mbox_wr_i    (mbox_wr_i),
  .bp_strobe_i  (bp_strobe_i),
  .bp_ack_i     (bp_ack_i),
  .bp_addr_i    (bp_addr_i),
  .win_hit_o    (win_hit_o),
  .mbox_irq_o   (mbox_irq_o),
  .berr_o       (berr_o),
  .csr_q        (csr_q)
);

// File: tb/shared_win_csr_tb_top.sv
module shared_win_csr_tb_top;
  localparam int CLK_HZ = 1_000_000;
  localparam int TMO_US = 128;
  localparam int TERM   = CLK_HZ / 1_000_000 * TMO_US;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        strap = 1'b0, sel = 1'b0, we = 1'b0, mbox = 1'b0;
  logic        stb = 1'b0, ack = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [23:0] bpa = '0;
  logic [7:0]  rdata;
  logic        hit, irq, berr;

  int n_chk = 0, n_fail = 0, berr_cnt = 0;

  // reference model state
  bit       m_pend, m_wen, m_ben, m_berr, m_prev, m_stop;
  bit [3:0] m_base;
  int       m_age;

  always #4 clk = ~clk;

  shared_win_csr #(.CLK_HZ(CLK_HZ), .TIMEOUT_US(TMO_US)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .slot1_strap_i(strap),
    .cpu_sel_i(sel), .cpu_we_i(we), .cpu_addr_i(addr), .cpu_wdata_i(wdata),
    .cpu_rdata_o(rdata), .mbox_wr_i(mbox), .bp_strobe_i(stb), .bp_ack_i(ack),
    .bp_addr_i(bpa), .win_hit_o(hit), .mbox_irq_o(irq), .berr_o(berr)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0; m_wen = 0; m_ben = 0; m_base = 0;
      m_berr = 0; m_prev = 0; m_stop = 0; m_age = 0;
    end else begin
      bit wr;
      wr = sel && we && addr == 3'd5;
      m_berr = 0;
      if (stb && !m_prev) begin m_age = 0; m_stop = 0; end
      else if (stb && ack) m_stop = 1;
      else if (stb && !m_stop && m_ben) begin
        if (m_age == TERM - 1) begin m_berr = 1; m_stop = 1; end
        else m_age++;
      end
      if (mbox) m_pend = 1;
      else if (wr && wdata[7]) m_pend = 0;
      if (wr) begin m_wen = wdata[6]; m_ben = wdata[5]; m_base = wdata[3:0]; end
      m_prev = stb;
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [7:0] exp_rd;
      exp_rd = (sel && addr == 3'd5) ? {m_pend, m_wen, m_ben, strap, m_base} : 8'h00;
      check("R2 rdata", rdata, exp_rd);
      check("R5 irq", {7'd0, irq}, {7'd0, m_pend});
      check("R7 hit", {7'd0, hit}, {7'd0, m_wen && stb && bpa[23:20] == m_base});
      check("R8 berr", {7'd0, berr}, {7'd0, m_berr});
      if (berr) berr_cnt++;
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d, input logic with_mbox = 0);
    tick(); sel = 1; we = 1; addr = a; wdata = d; mbox = with_mbox;
    tick(); sel = 0; we = 0; mbox = 0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] exp);
    tick(); sel = 1; we = 0; addr = 3'd5;
    @(negedge clk); check(req, rdata, exp);
    tick(); sel = 0;
  endtask

  task automatic hold_stb(input int n);
    stb = 1; repeat (n) tick(); stb = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1 irq", {7'd0, irq}, 8'd0);
    check("R1 berr", {7'd0, berr}, 8'd0);
    rd_chk("R1 reset value", 8'h00);
    strap = 1;
    rd_chk("R1 R4 strap slot1", 8'h10);
    wr_reg(3'd5, 8'hFF);
    rd_chk("R3 R4 write all ones", 8'h7F);
    strap = 0;
    rd_chk("R4 strap follows", 8'h6F);
    wr_reg(3'd4, 8'h00);
    tick(); we = 1; addr = 3'd5; wdata = 8'h00; tick(); we = 0;
    rd_chk("R3 foreign offset / no select", 8'h6F);
    // mailbox
    tick(); mbox = 1; tick(); mbox = 0;
    @(negedge clk); check("R5 irq set", {7'd0, irq}, 8'd1);
    wr_reg(3'd5, 8'h6F);
    rd_chk("R6 write zero keeps pend", 8'hEF);
    wr_reg(3'd5, 8'hEF, 1'b1);
    rd_chk("R6 set beats clear", 8'hEF);
    wr_reg(3'd5, 8'hC3);
    rd_chk("R6 write one clears", 8'h43);
    // window sweep: enabled base 3, then disabled
    for (int pass = 0; pass < 2; pass++) begin
      for (int n = 0; n < 16; n++) begin
        tick(); bpa = {n[3:0], 20'h5A5A5}; stb = 1;
        @(negedge clk);
        check("R7 sweep", {7'd0, hit}, {7'd0, (pass == 0) && n == 3});
        tick(); stb = 0;
        @(negedge clk); check("R7 no strobe", {7'd0, hit}, 8'd0);
      end
      wr_reg(3'd5, 8'h03);
    end
    // bus monitor
    wr_reg(3'd5, 8'h23);
    berr_cnt = 0; hold_stb(TERM + 10); repeat (2) tick();
    check("R8 one pulse on timeout", 8'(berr_cnt), 8'd1);
    berr_cnt = 0; stb = 1; repeat (TERM / 2) tick();
    ack = 1; tick(); ack = 0; repeat (TERM + 10) tick(); stb = 0; repeat (2) tick();
    check("R9 ack stops timer", 8'(berr_cnt), 8'd0);
    berr_cnt = 0; hold_stb(TERM - 2); tick(); hold_stb(TERM - 2); repeat (2) tick();
    check("R9 restart reloads", 8'(berr_cnt), 8'd0);
    wr_reg(3'd5, 8'h03);
    berr_cnt = 0; hold_stb(TERM + 10); repeat (2) tick();
    check("R10 monitor off", 8'(berr_cnt), 8'd0);
    repeat (4) tick();
    finish_run();
  end
endmodule